// File: doc/BRIEF.md
# Interrupt-Enable Flag Control Unit

This block holds a processor core's maskable-interrupt enable flag (IF), its virtual interrupt flag (VIF) and a one-instruction interrupt shadow. The retire stage presents one retiring instruction per cycle as an opcode class with a lock-prefix bit. When the class is the set-interrupt-flag operation, the block resolves the current operating mode, privilege level and I/O privilege level into one of four outcomes: it sets IF, sets VIF, raises a general-protection fault (error code zero), or raises an undefined-opcode fault. A clear-interrupt-flag class drops IF. Every other class passes through and changes no flag.

Each retire boundary is also an interrupt recognition point. A maskable request is accepted when IF is set, no shadow is open and the retiring instruction did not fault. Enabling IF from a cleared state opens a shadow. The shadow hides that boundary from maskable interrupts, and optionally from the non-maskable request, until the next instruction retires or another event is delivered.

Top module: `intr_enable_ctl`

## Requirements
- R1: A retire whose class equals SET_CODE (default 0xFB) is the set operation, and one equal to CLR_CODE (default 0xFA) clears IF. Any other class changes neither IF, VIF nor the shadow state, apart from closing the shadow.
- R2: A set operation with the lock bit high raises `ud_fault` in its retire cycle in every mode, and it changes no flag.
- R3: With protection disabled (`mode_pe`=0), the set operation sets IF, whatever the other mode bits, the privilege levels or `vip` hold.
- R4: With protection enabled, the effective privilege is 3 when `mode_v86` or `mode_pvi` is high and `cpl` otherwise. The set operation sets IF when `iopl` is at least the effective privilege.
- R5: With protection enabled and `iopl` below the effective privilege, the set operation sets VIF and leaves IF unchanged when the virtual extension is on (`mode_vme` in virtual-8086 mode, `mode_pvi` otherwise) and `vip` is 0.
- R6: In every other case where `iopl` is below the effective privilege, `gp_fault` pulses in the retire cycle and no flag changes.
- R7: A set operation that sets IF while IF was 0 opens the shadow (`shadow_active`=1). No maskable interrupt is accepted at that boundary. The shadow closes at the next retire, which may accept, or when `event_dlv` is high.
- R8: A set operation with IF=0 followed directly by a clear operation accepts no maskable interrupt at either boundary.
- R9: `int_accept` is high in a cycle exactly when `retire_vld` is high, no fault is raised, any `irq_req` bit is set, and IF after the retire is 1 while the shadow after it is closed.
- R10: `nmi_accept` is high when `retire_vld` and `nmi_req` are high and no fault is raised. With NMI_SHADOW=1 it is additionally held low when the shadow after the retire is open.
- R11: After reset, IF, VIF and the shadow are 0.
- R12: At most one of IF and VIF changes for a single retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_vld | input | 1 | An instruction retires this cycle |
| retire_opc | input | OPC_W | Opcode class of the retiring instruction |
| retire_lock | input | 1 | Lock prefix present |
| mode_pe | input | 1 | Protection enabled |
| mode_v86 | input | 1 | Virtual-8086 mode |
| mode_vme | input | 1 | Virtual-8086 interrupt extension enabled |
| mode_pvi | input | 1 | Protected-mode virtual interrupts active |
| cpl | input | PRIV_W | Current privilege level |
| iopl | input | PRIV_W | I/O privilege level |
| vip | input | 1 | Virtual interrupt pending |
| event_dlv | input | 1 | Another event (exception) is being delivered |
| irq_req | input | NUM_IRQ | Maskable interrupt requests |
| nmi_req | input | 1 | Non-maskable interrupt request |
| if_flag | output | 1 | Interrupt enable flag |
| vif_flag | output | 1 | Virtual interrupt flag |
| shadow_active | output | 1 | Interrupt shadow open |
| gp_fault | output | 1 | General-protection fault strobe, error code zero |
| ud_fault | output | 1 | Undefined-opcode fault strobe |
| int_accept | output | 1 | Maskable interrupt accepted at this boundary |
| nmi_accept | output | 1 | Non-maskable interrupt accepted at this boundary |

## Verification
The fault strobes and both accept outputs are combinational from the retire cycle. The bench drives each retire on a falling edge and samples these outputs one nanosecond later, before the rising edge that commits the retire. IF, VIF and the shadow are registered, so their new values are due after that one rising edge, and the bench reads them on the next falling edge. It sweeps all 2048 combinations of mode bits, privilege levels, pending bit, lock bit and starting IF, and computes the outcome arithmetically. Directed sequences then cover the shadow across two and three retires.

// File: rtl/ief_pkg.sv
package ief_pkg;
   typedef enum logic [1:0] {
      ACT_SET_IF  = 2'd0,
      ACT_SET_VIF = 2'd1,
      ACT_GP      = 2'd2,
      ACT_UD      = 2'd3
   } ief_act_e;
endpackage

// File: rtl/ief_rules.sv
module ief_rules
   import ief_pkg::*;
#(
   parameter int PRIV_W = 2
) (
   input  logic              pe,
   input  logic              v86,
   input  logic              vme,
   input  logic              pvi,
   input  logic              lock,
   input  logic              vip,
   input  logic [PRIV_W-1:0] cpl,
   input  logic [PRIV_W-1:0] iopl,
   output ief_act_e          act
);
   localparam logic [PRIV_W-1:0] LEAST_PRIV = '1;

   if (PRIV_W < 1) begin : g_bad_priv
      $error("PRIV_W must be at least 1");
   end

   logic [PRIV_W-1:0] eff_cpl;
   logic              ext_on;

   always_comb begin
      eff_cpl = (v86 || pvi) ? LEAST_PRIV : cpl;
      ext_on  = v86 ? vme : pvi;
      if (lock)                 act = ACT_UD;
      else if (!pe)             act = ACT_SET_IF;
      else if (iopl >= eff_cpl) act = ACT_SET_IF;
      else if (ext_on && !vip)  act = ACT_SET_VIF;
      else                      act = ACT_GP;
   end
endmodule

// File: rtl/ief_flags.sv
module ief_flags
   import ief_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     retire,
   input  logic     op_set,
   input  logic     op_clr,
   input  ief_act_e act,
   input  logic     event_dlv,
   output logic     if_q,
   output logic     vif_q,
   output logic     shd_q,
   output logic     if_nx,
   output logic     shd_nx
);
   logic vif_nx;

   always_comb begin
      if_nx  = if_q;
      vif_nx = vif_q;
      shd_nx = shd_q;
      if (event_dlv) shd_nx = 1'b0;
      if (retire) begin
         shd_nx = 1'b0;
         if (op_set) begin
            case (act)
               ACT_SET_IF: begin
                  if_nx  = 1'b1;
                  shd_nx = !if_q;
               end
               ACT_SET_VIF: vif_nx = 1'b1;
               default: ;
            endcase
         end else if (op_clr) begin
            if_nx = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         if_q  <= 1'b0;
         vif_q <= 1'b0;
         shd_q <= 1'b0;
      end else begin
         if_q  <= if_nx;
         vif_q <= vif_nx;
         shd_q <= shd_nx;
      end
   end

   AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({if_q != $past(if_q), vif_q != $past(vif_q)}) <= 1); // R12
   AST_SHADOW_WITH_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shd_q) |-> $rose(if_q)); // R7
   AST_VIF_KEEPS_IF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vif_q) |-> $stable(if_q)); // R5
endmodule

// File: rtl/ief_gate.sv
module ief_gate #(
   parameter int NUM_IRQ    = 4,
   parameter bit NMI_SHADOW = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               retire,
   input  logic               fault,
   input  logic               if_nx,
   input  logic               shd_nx,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic               nmi_req,
   output logic               int_accept,
   output logic               nmi_accept
);
   if (NUM_IRQ < 1) begin : g_bad_irq
      $error("NUM_IRQ must be at least 1");
   end

   logic boundary;
   logic nmi_block;

   assign boundary = retire && !fault;

   if (NMI_SHADOW) begin : g_nmi_shadowed
      assign nmi_block = shd_nx;
   end else begin : g_nmi_free
      assign nmi_block = 1'b0;
   end

   assign int_accept = boundary && (|irq_req) && if_nx && !shd_nx;
   assign nmi_accept = boundary && nmi_req && !nmi_block;

   AST_ACCEPT_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (int_accept || nmi_accept) |-> retire); // R9
   AST_NMI_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_accept |-> nmi_req); // R10
endmodule

// File: rtl/intr_enable_ctl.sv
module intr_enable_ctl
   import ief_pkg::*;
#(
   parameter int                OPC_W      = 8,
   parameter logic [OPC_W-1:0]  SET_CODE   = 8'hFB,
   parameter logic [OPC_W-1:0]  CLR_CODE   = 8'hFA,
   parameter int                PRIV_W     = 2,
   parameter int                NUM_IRQ    = 4,
   parameter bit                NMI_SHADOW = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               retire_vld,
   input  logic [OPC_W-1:0]   retire_opc,
   input  logic               retire_lock,
   input  logic               mode_pe,
   input  logic               mode_v86,
   input  logic               mode_vme,
   input  logic               mode_pvi,
   input  logic [PRIV_W-1:0]  cpl,
   input  logic [PRIV_W-1:0]  iopl,
   input  logic               vip,
   input  logic               event_dlv,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic               nmi_req,
   output logic               if_flag,
   output logic               vif_flag,
   output logic               shadow_active,
   output logic               gp_fault,
   output logic               ud_fault,
   output logic               int_accept,
   output logic               nmi_accept
);
   if (SET_CODE == CLR_CODE) begin : g_bad_codes
      $error("SET_CODE and CLR_CODE must differ");
   end

   ief_act_e act;
   logic     op_set, op_clr, fault, if_nx, shd_nx;

   assign op_set   = retire_vld && (retire_opc == SET_CODE);
   assign op_clr   = retire_vld && (retire_opc == CLR_CODE);
   assign gp_fault = op_set && (act == ACT_GP);
   assign ud_fault = op_set && (act == ACT_UD);
   assign fault    = gp_fault || ud_fault;

   ief_rules #(.PRIV_W(PRIV_W)) u_rules (
      .pe(mode_pe), .v86(mode_v86), .vme(mode_vme), .pvi(mode_pvi),
      .lock(retire_lock), .vip(vip), .cpl(cpl), .iopl(iopl), .act(act)
   );

   ief_flags u_flags (
      .clk(clk), .rst_n(rst_n), .retire(retire_vld), .op_set(op_set),
      .op_clr(op_clr), .act(act), .event_dlv(event_dlv),
      .if_q(if_flag), .vif_q(vif_flag), .shd_q(shadow_active),
      .if_nx(if_nx), .shd_nx(shd_nx)
   );

   ief_gate #(.NUM_IRQ(NUM_IRQ), .NMI_SHADOW(NMI_SHADOW)) u_gate (
      .clk(clk), .rst_n(rst_n), .retire(retire_vld), .fault(fault),
      .if_nx(if_nx), .shd_nx(shd_nx), .irq_req(irq_req), .nmi_req(nmi_req),
      .int_accept(int_accept), .nmi_accept(nmi_accept)
   );

   AST_ACCEPT_LEAVES_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      int_accept |=> (if_flag && !shadow_active)); // R9
   AST_FAULT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (gp_fault || ud_fault) |=> ($stable(if_flag) && $stable(vif_flag))); // R6
   AST_UD_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      ud_fault |-> retire_lock); // R2
   AST_FAULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gp_fault, ud_fault, int_accept})); // R9
   AST_NMI_OUTSIDE_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_accept && NMI_SHADOW) |=> !shadow_active); // R10
endmodule

// File: tb/intr_enable_ctl_test.sv
`timescale 1ns/1ps
module intr_enable_ctl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       retire_vld = 1'b0;
   logic [7:0] retire_opc = 8'h90;
   logic       retire_lock = 1'b0;
   logic       mode_pe = 1'b0, mode_v86 = 1'b0, mode_vme = 1'b0, mode_pvi = 1'b0;
   logic [1:0] cpl = 2'd0, iopl = 2'd0;
   logic       vip = 1'b0, event_dlv = 1'b0, nmi_req = 1'b0;
   logic [3:0] irq_req = 4'd0;
   logic       if_flag, vif_flag, shadow_active, gp_fault, ud_fault, int_accept, nmi_accept;
   int         errors = 0, checks = 0;

   always #2.5 clk = ~clk;

   intr_enable_ctl uut (.*);

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; retire_vld = 1'b0; event_dlv = 1'b0;
      step(); step();
      rst_n = 1'b1;
   endtask

   // Drive one retire at a falling edge; combinational outputs read after #1.
   task automatic retire(input logic [7:0] opc, input logic lk);
      retire_opc = opc; retire_lock = lk; retire_vld = 1'b1;
      #1;
   endtask

   task automatic finish_retire();
      step();
      retire_vld = 1'b0; retire_lock = 1'b0;
   endtask

   initial begin
      #2ms;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      chk("R11 if", if_flag, 1'b0);
      chk("R11 vif", vif_flag, 1'b0);
      chk("R11 shadow", shadow_active, 1'b0);

      // Exhaustive sweep: R2 R3 R4 R5 R6 R9 R10 R12
      for (int k = 0; k < 2048; k++) begin
         automatic logic ifi = k[10];
         automatic int   eff, code;
         automatic logic ext, ifx, shx, flt;
         do_reset();
         irq_req = 4'b0101; nmi_req = 1'b1;
         mode_pe = 1'b0; mode_v86 = 1'b0; mode_vme = 1'b0; mode_pvi = 1'b0;
         if (ifi) begin
            retire(8'hFB, 1'b0); finish_retire();
            retire(8'h90, 1'b0); finish_retire();
         end
         mode_pe = k[0]; mode_v86 = k[1]; mode_vme = k[2]; mode_pvi = k[3];
         cpl = k[5:4]; iopl = k[7:6]; vip = k[8];
         eff = (k[1] || k[3]) ? 3 : int'(k[5:4]);
         ext = k[1] ? k[2] : k[3];
         if (k[9])                   code = 3;
         else if (!k[0])             code = 0;
         else if (int'(k[7:6]) >= eff) code = 0;
         else if (ext && !k[8])      code = 1;
         else                        code = 2;
         ifx = ifi || (code == 0);
         shx = (code == 0) && !ifi;
         flt = (code >= 2);
         retire(8'hFB, k[9]);
         chk("R6 gp", gp_fault, code == 2);
         chk("R2 ud", ud_fault, code == 3);
         chk("R9 int", int_accept, !flt && ifx && !shx);
         chk("R10 nmi", nmi_accept, !flt && !shx);
         finish_retire();
         chk("R3 R4 if", if_flag, ifx);
         chk("R5 vif", vif_flag, code == 1);
         chk("R7 shadow", shadow_active, shx);
      end

      // R7: shadow hides one boundary, next retire accepts
      do_reset();
      mode_pe = 1'b0; irq_req = 4'b1000; nmi_req = 1'b1;
      retire(8'hFB, 1'b0);
      chk("R7 no accept at enable", int_accept, 1'b0);
      chk("R10 nmi blocked in shadow", nmi_accept, 1'b0);
      finish_retire();
      chk("R7 shadow open", shadow_active, 1'b1);
      retire(8'hC3, 1'b0);
      chk("R7 accept after next", int_accept, 1'b1);
      finish_retire();
      chk("R7 shadow closed", shadow_active, 1'b0);

      // R7: event delivery closes the shadow
      do_reset();
      retire(8'hFB, 1'b0); finish_retire();
      event_dlv = 1'b1; step(); event_dlv = 1'b0;
      chk("R7 event closes", shadow_active, 1'b0);

      // R8: set then clear accepts nothing
      do_reset();
      irq_req = 4'b0001;
      retire(8'hFB, 1'b0);
      chk("R8 first", int_accept, 1'b0);
      finish_retire();
      retire(8'hFA, 1'b0);
      chk("R8 second", int_accept, 1'b0);
      finish_retire();
      chk("R8 if cleared", if_flag, 1'b0);

      // R9: no retire, no accept; no request, no accept
      retire(8'hFB, 1'b0); finish_retire();
      retire(8'h90, 1'b0); finish_retire();
      #1;
      chk("R9 idle", int_accept, 1'b0);
      irq_req = 4'b0000;
      retire(8'h90, 1'b0);
      chk("R9 no request", int_accept, 1'b0);
      finish_retire();

      // R1: other classes leave flags
      retire(8'h5B, 1'b1);
      chk("R1 no ud", ud_fault, 1'b0);
      finish_retire();
      chk("R1 if kept", if_flag, 1'b1);
      chk("R1 vif kept", vif_flag, 1'b0);
      chk("R1 shadow kept", shadow_active, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule